// File: doc/BRIEF.md
# Load Switch Fault Supervisor

This block supervises a current-limited power load switch from the digital side. It receives an enable request, a supply voltage code, a flag that says the analog regulator is limiting current, and a junction temperature code. From these it decides when the gate of the pass switch may be driven, and whether the open-drain fault pin should be pulled low. The fault pin is modelled as a drive-low request: 1 means pull the pad low, and 0 means the pad floats.

All four status inputs arrive asynchronously and pass through a synchronizer chain. Supply lockout and thermal shutdown each use hysteresis, held in registered flags. The thermal trip level is lower while the regulator is limiting current. After a thermal shutdown the block restarts by itself once the die has cooled by a set number of codes.

The fault report is filtered at both edges by a timer of `DG_CYCLES` clocks. A short overload restarts that timer from zero, so repeated short pulses never add up to a report. A thermal trip that happens while the switch is limiting current raises the flag at once, but the flag still drops only after the full filter time. Removing the enable, or losing the supply, releases the pin at once.

Top module: `load_switch_supervisor`

## Requirements
- R1: While `rst` is high and after it falls, with no enable, `gate_en_o` is 0 and `fault_drive_o` is 0.
- R2: The gate is driven only after the synchronized supply code has reached `UV_RISE` (default 200). A code of `UV_RISE-1` keeps `gate_en_o` at 0.
- R3: Once the supply is accepted, it is dropped only when the code falls below `UV_RISE-UV_HYST` (default 194). A code equal to 194 keeps the gate on, and 193 turns it off.
- R4: Thermal shutdown trips when the temperature code reaches `TSD_NORM` (default 155) while not limiting, or `TSD_LIM` (default 135) while limiting. A trip forces `gate_en_o` to 0. A code of 140 without limiting does not trip.
- R5: After a shutdown, the gate stays off until the code is at or below the trip level minus `TSD_HYST` (default 20). It then restarts by itself, and the gate rises no earlier than one clock after the restart decision.
- R6: An overload (limit flag with gate on) or a thermal shutdown lasting `DG_CYCLES` consecutive synchronized clocks raises `fault_drive_o`. A shorter one does not raise it.
- R7: An overload that ends before the filter time clears the timer, so repeated short pulses separated by idle clocks never raise the flag.
- R8: A thermal trip at the limiting threshold (the limit flag was set when it tripped) raises the flag within one clock of the trip, with no filter delay.
- R9: Once raised, the flag stays up until its cause has been absent for `DG_CYCLES` consecutive clocks, including after a thermal restart.
- R10: Dropping the enable, or a supply lockout, releases `fault_drive_o` at once, turns the gate off, and clears the filter timer.
- R11: With enable and supply valid but no overload and no shutdown, `fault_drive_o` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Asynchronous switch enable request |
| ilim_i | input | 1 | Asynchronous flag: the analog regulator is limiting current |
| vin_code_i | input | VIN_W | Asynchronous unsigned supply voltage code |
| temp_code_i | input | TEMP_W | Asynchronous unsigned junction temperature code |
| gate_en_o | output | 1 | Drive the pass switch gate |
| fault_drive_o | output | 1 | 1 pulls the open-drain fault pad low, 0 leaves it floating |

## Verification
The interesting collision is a thermal trip and a running overload filter in the same cycle. The bench raises the limit flag and a temperature code of 135 together, so the filter timer is counting when the shutdown register sets. It then checks that the flag appears long before `DG_CYCLES`, and that the release after cooling still takes the full filter time. A second overlap is a disable or supply loss that arrives while a fault is raised and its cause is still present. The bench checks that the pin floats within the synchronizer latency, and that re-enabling starts a fresh filter interval rather than resuming the old one.

// File: rtl/lss_pkg.sv
package lss_pkg;

   // Lower edge of a hysteresis band: the level below which an accepted
   // condition is dropped again.
   function automatic int unsigned lower_edge(int unsigned thr, int unsigned hyst);
      return thr - hyst;
   endfunction

   typedef enum logic [1:0] {
      SW_OFF  = 2'd0,
      SW_ON   = 2'd1,
      SW_HOT  = 2'd2
   } sw_state_e;

endpackage

// File: rtl/lss_sync.sv
module lss_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lss_uvlo.sv
module lss_uvlo #(
   parameter int W    = 8,
   parameter int RISE = 200,
   parameter int HYST = 6
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] code_i,
   output logic         ok_o
);
   localparam logic [W-1:0] RISE_C = W'(RISE);
   localparam logic [W-1:0] LO_C   = W'(lss_pkg::lower_edge(RISE, HYST));

   logic ok_q;

   always_ff @(posedge clk) begin
      if (rst)                  ok_q <= 1'b0;
      else if (!ok_q)           ok_q <= (code_i >= RISE_C);
      else if (code_i < LO_C)   ok_q <= 1'b0;
   end

   assign ok_o = ok_q;

   p_rise_r2: assert property (@(posedge clk) disable iff (rst)
      (!ok_q && code_i < RISE_C) |=> !ok_q);
   p_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (ok_q && code_i >= LO_C) |=> ok_q);
endmodule

// File: rtl/lss_thermal.sv
module lss_thermal #(
   parameter int W        = 8,
   parameter int TRIP_NRM = 155,
   parameter int TRIP_LIM = 135,
   parameter int HYST     = 20
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] temp_i,
   input  logic         limiting_i,
   output logic         shut_o,
   output logic         lim_trip_o,
   output logic         restart_o
);
   localparam logic [W-1:0] NRM_C  = W'(TRIP_NRM);
   localparam logic [W-1:0] LIM_C  = W'(TRIP_LIM);
   localparam logic [W-1:0] HYST_C = W'(HYST);

   logic         shut_q, lim_trip_q, restart_q;
   logic [W-1:0] lvl_q;
   logic [W-1:0] trip_now;
   logic [W-1:0] cool_lvl;

   assign trip_now = limiting_i ? LIM_C : NRM_C;
   assign cool_lvl = lvl_q - HYST_C;

   always_ff @(posedge clk) begin
      if (rst) begin
         shut_q     <= 1'b0;
         lim_trip_q <= 1'b0;
         restart_q  <= 1'b0;
         lvl_q      <= NRM_C;
      end else begin
         restart_q <= 1'b0;
         if (!shut_q) begin
            if (temp_i >= trip_now) begin
               shut_q     <= 1'b1;
               lim_trip_q <= limiting_i;
               lvl_q      <= trip_now;
            end
         end else if (temp_i <= cool_lvl) begin
            shut_q     <= 1'b0;
            lim_trip_q <= 1'b0;
            restart_q  <= 1'b1;
         end
      end
   end

   assign shut_o     = shut_q;
   assign lim_trip_o = lim_trip_q;
   assign restart_o  = restart_q;

   p_trip_r4: assert property (@(posedge clk) disable iff (rst)
      (!shut_q && temp_i >= trip_now) |=> shut_q);
   p_stay_hot_r5: assert property (@(posedge clk) disable iff (rst)
      (shut_q && temp_i > cool_lvl) |=> shut_q);
   p_restart_once_r5: assert property (@(posedge clk) disable iff (rst)
      restart_q |-> (!shut_q && $past(shut_q)));
endmodule

// File: rtl/lss_fault_deglitch.sv
module lss_fault_deglitch #(
   parameter int DG_CYCLES = 400000
) (
   input  logic clk,
   input  logic rst,
   input  logic arm_i,
   input  logic cause_i,
   input  logic fast_i,
   input  logic restart_i,
   output logic flag_o
);
   localparam int CW = (DG_CYCLES > 2) ? $clog2(DG_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(DG_CYCLES - 1);

   logic          flg_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         flg_q <= 1'b0;
         cnt_q <= '0;
      end else if (!arm_i) begin
         flg_q <= 1'b0;
         cnt_q <= '0;
      end else if (restart_i) begin
         cnt_q <= '0;
      end else if (!flg_q) begin
         if (fast_i) begin
            flg_q <= 1'b1;
            cnt_q <= '0;
         end else if (cause_i) begin
            if (cnt_q == LAST) begin
               flg_q <= 1'b1;
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else begin
            cnt_q <= '0;
         end
      end else begin
         if (cause_i) begin
            cnt_q <= '0;
         end else if (cnt_q == LAST) begin
            flg_q <= 1'b0;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign flag_o = flg_q;

   p_no_early_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(flg_q) |-> ($past(fast_i) || $past(cnt_q) == LAST));
   p_short_clear_r7: assert property (@(posedge clk) disable iff (rst)
      (arm_i && !flg_q && !cause_i && !fast_i) |=> (cnt_q == '0));
   p_fast_r8: assert property (@(posedge clk) disable iff (rst)
      (arm_i && fast_i) |=> flg_q);
   p_release_r9: assert property (@(posedge clk) disable iff (rst)
      ($fell(flg_q) && $past(arm_i)) |-> ($past(cnt_q) == LAST && !$past(cause_i)));
   p_drop_r10: assert property (@(posedge clk) disable iff (rst)
      !arm_i |=> (!flg_q && cnt_q == '0));
   p_no_cause_r11: assert property (@(posedge clk) disable iff (rst)
      (!flg_q && !cause_i && !fast_i) |=> !flg_q);
endmodule

// File: rtl/load_switch_supervisor.sv
module load_switch_supervisor #(
   parameter int VIN_W       = 8,
   parameter int TEMP_W      = 8,
   parameter int UV_RISE     = 200,
   parameter int UV_HYST     = 6,
   parameter int TSD_NORM    = 155,
   parameter int TSD_LIM     = 135,
   parameter int TSD_HYST    = 20,
   parameter int DG_CYCLES   = 400000,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en_i,
   input  logic              ilim_i,
   input  logic [VIN_W-1:0]  vin_code_i,
   input  logic [TEMP_W-1:0] temp_code_i,
   output logic              gate_en_o,
   output logic              fault_drive_o
);
   import lss_pkg::*;

   localparam int SW = 2 + VIN_W + TEMP_W;

   // Elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DG_CYCLES < 2) begin : g_chk_dg
      $error("DG_CYCLES must be at least 2");
   end
   if (UV_HYST >= UV_RISE || UV_RISE >= (1 << VIN_W)) begin : g_chk_uv
      $error("supply thresholds do not fit VIN_W");
   end
   if (TSD_HYST >= TSD_LIM || TSD_LIM > TSD_NORM || TSD_NORM >= (1 << TEMP_W)) begin : g_chk_tsd
      $error("thermal thresholds inconsistent");
   end

   logic [SW-1:0]     raw_bus, syn_bus;
   logic              en_s, ilim_s;
   logic [VIN_W-1:0]  vin_s;
   logic [TEMP_W-1:0] temp_s;
   logic              vin_ok, shut, lim_trip, restart, flag;
   logic              limiting, arm, cause;
   sw_state_e         sw_q;
   logic              gate_q;

   assign raw_bus = {en_i, ilim_i, vin_code_i, temp_code_i};

   lss_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d_i(raw_bus), .q_o(syn_bus)
   );

   assign {en_s, ilim_s, vin_s, temp_s} = syn_bus;

   lss_uvlo #(.W(VIN_W), .RISE(UV_RISE), .HYST(UV_HYST)) u_uvlo (
      .clk(clk), .rst(rst), .code_i(vin_s), .ok_o(vin_ok)
   );

   assign limiting = ilim_s & gate_q;

   lss_thermal #(.W(TEMP_W), .TRIP_NRM(TSD_NORM), .TRIP_LIM(TSD_LIM), .HYST(TSD_HYST)) u_therm (
      .clk(clk), .rst(rst), .temp_i(temp_s), .limiting_i(limiting),
      .shut_o(shut), .lim_trip_o(lim_trip), .restart_o(restart)
   );

   // Switch state: off, conducting, or held off by the thermal loop
   always_ff @(posedge clk) begin
      if (rst) begin
         sw_q <= SW_OFF;
      end else if (!(en_s && vin_ok)) begin
         sw_q <= SW_OFF;
      end else if (shut) begin
         sw_q <= SW_HOT;
      end else begin
         sw_q <= SW_ON;
      end
   end

   assign gate_q = (sw_q == SW_ON);
   assign arm    = en_s & vin_ok;
   assign cause  = limiting | shut;

   lss_fault_deglitch #(.DG_CYCLES(DG_CYCLES)) u_dg (
      .clk(clk), .rst(rst), .arm_i(arm), .cause_i(cause),
      .fast_i(shut & lim_trip), .restart_i(restart), .flag_o(flag)
   );

   assign gate_en_o     = gate_q;
   assign fault_drive_o = flag & arm;

   p_gate_supply_r2: assert property (@(posedge clk) disable iff (rst)
      gate_q |-> $past(vin_ok));
   p_gate_hot_r4: assert property (@(posedge clk) disable iff (rst)
      shut |=> !gate_q);
   p_gate_late_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_q) |-> (!$past(shut) && !shut));
   p_gate_drop_r10: assert property (@(posedge clk) disable iff (rst)
      !arm |=> !gate_q);
endmodule

// File: tb/tb_load_switch_supervisor.sv
module tb_load_switch_supervisor;
   localparam int DG = 20;

   logic       clk = 1'b0;
   logic       rst;
   logic       en_i, ilim_i;
   logic [7:0] vin_code_i, temp_code_i;
   logic       gate_en_o, fault_drive_o;

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   load_switch_supervisor #(.DG_CYCLES(DG)) dut (
      .clk(clk), .rst(rst), .en_i(en_i), .ilim_i(ilim_i),
      .vin_code_i(vin_code_i), .temp_code_i(temp_code_i),
      .gate_en_o(gate_en_o), .fault_drive_o(fault_drive_o)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic t_reset;
      rst = 1'b1; en_i = 1'b0; ilim_i = 1'b0; vin_code_i = 8'd0; temp_code_i = 8'd25;
      tick(3);
      chk("R1 gate in reset", gate_en_o, 1'b0);
      rst = 1'b0;
      tick(5);
      chk("R1 gate after reset", gate_en_o, 1'b0);
      chk("R1 fault after reset", fault_drive_o, 1'b0);
   endtask

   task automatic t_uvlo;
      en_i = 1'b1; vin_code_i = 8'd199;
      tick(10); chk("R2 below rise", gate_en_o, 1'b0);
      vin_code_i = 8'd200;
      tick(6);  chk("R2 at rise", gate_en_o, 1'b1);
      vin_code_i = 8'd194;
      tick(6);  chk("R3 at lower edge", gate_en_o, 1'b1);
      vin_code_i = 8'd193;
      tick(6);  chk("R3 below lower edge", gate_en_o, 1'b0);
      vin_code_i = 8'd220;
      tick(6);  chk("R2 recover", gate_en_o, 1'b1);
   endtask

   task automatic t_no_cause;
      logic seen = 1'b0;
      for (int i = 0; i < 50; i++) begin
         tick(1);
         seen = seen | fault_drive_o;
      end
      chk("R11 idle no fault", seen, 1'b0);
   endtask

   task automatic t_assert_release;
      ilim_i = 1'b1;
      tick(DG - 2); chk("R6 not yet", fault_drive_o, 1'b0);
      tick(6);      chk("R6 asserted", fault_drive_o, 1'b1);
      ilim_i = 1'b0;
      tick(DG - 2); chk("R9 held", fault_drive_o, 1'b1);
      tick(6);      chk("R9 released", fault_drive_o, 1'b0);
   endtask

   task automatic t_short_pulses;
      logic seen = 1'b0;
      for (int p = 0; p < 6; p++) begin
         ilim_i = 1'b1;
         for (int i = 0; i < DG - 4; i++) begin tick(1); seen = seen | fault_drive_o; end
         ilim_i = 1'b0;
         for (int i = 0; i < 3; i++) begin tick(1); seen = seen | fault_drive_o; end
      end
      tick(DG);
      chk("R7 short pulses no fault", seen | fault_drive_o, 1'b0);
   endtask

   task automatic t_disable;
      ilim_i = 1'b1;
      tick(DG + 6); chk("R6 pre-disable", fault_drive_o, 1'b1);
      en_i = 1'b0;
      tick(4);
      chk("R10 disable fault", fault_drive_o, 1'b0);
      chk("R10 disable gate", gate_en_o, 1'b0);
      en_i = 1'b1;
      tick(6); chk("R10 timer cleared", fault_drive_o, 1'b0);
      ilim_i = 1'b0;
      tick(DG + 6);
   endtask

   task automatic t_uv_release;
      ilim_i = 1'b1;
      tick(DG + 6); chk("R6 pre-lockout", fault_drive_o, 1'b1);
      vin_code_i = 8'd150;
      tick(3); chk("R10 lockout fault", fault_drive_o, 1'b0);
      tick(2); chk("R10 lockout gate", gate_en_o, 1'b0);
      ilim_i = 1'b0; vin_code_i = 8'd220;
      tick(8);
   endtask

   task automatic t_therm_norm;
      temp_code_i = 8'd140;
      tick(8); chk("R4 140 no limit", gate_en_o, 1'b1);
      temp_code_i = 8'd155;
      tick(6);
      chk("R4 trip 155", gate_en_o, 1'b0);
      chk("R6 overtemp filtered", fault_drive_o, 1'b0);
      tick(DG); chk("R6 overtemp reported", fault_drive_o, 1'b1);
      temp_code_i = 8'd136;
      tick(8); chk("R5 still hot", gate_en_o, 1'b0);
      temp_code_i = 8'd135;
      tick(6);
      chk("R5 restart", gate_en_o, 1'b1);
      chk("R9 held after restart", fault_drive_o, 1'b1);
      tick(DG + 4); chk("R9 released after restart", fault_drive_o, 1'b0);
   endtask

   task automatic t_therm_lim;
      temp_code_i = 8'd25;
      tick(4);
      ilim_i = 1'b1; temp_code_i = 8'd135;
      tick(7);
      chk("R8 immediate fault", fault_drive_o, 1'b1);
      chk("R4 trip 135 limiting", gate_en_o, 1'b0);
      ilim_i = 1'b0; temp_code_i = 8'd120;
      tick(8); chk("R5 limit trip still hot", gate_en_o, 1'b0);
      temp_code_i = 8'd115;
      tick(6);
      chk("R5 restart from limit trip", gate_en_o, 1'b1);
      chk("R9 release still filtered", fault_drive_o, 1'b1);
      tick(DG + 4); chk("R9 released", fault_drive_o, 1'b0);
   endtask

   initial begin
      #4000000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      tick(1);
      t_reset;
      t_uvlo;
      t_no_cause;
      t_assert_release;
      t_short_pulses;
      t_disable;
      t_uv_release;
      t_therm_norm;
      t_therm_lim;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule